// File: doc/BRIEF.md
# Two-Stage Seconds Divider with Subsecond Readout

This block turns a slow real-time reference clock into a one-second tick. A 7-bit asynchronous down-counter divides the reference into an intermediate enable pulse. A 15-bit synchronous down-counter advances once per pulse. When the synchronous counter wraps, the block issues the seconds tick. The live value of the synchronous counter is brought out as a subsecond count. The elapsed fraction of the current second is (S − subsec) / (S + 1), where S is the synchronous divider value.

Both divider values are held in registers. They can only be changed through an initialization handshake. The user raises an init request and waits for the ready flag. The block accepts a single write of both dividers. The user then drops the request, and counting resumes after a fixed restart delay. The tick rate is f_clk / ((A + 1) × (S + 1)). For example, A = 127 and S = 255 give 1 Hz from 32768 Hz, and A = 99 and S = 9999 give 1 Hz from 1 MHz.

Top module: `rtc_tick_divider`

## Requirements
- R1: After synchronous reset the dividers are A = 127 and S = 255. `subsec` reads 255, `init_ready` reads 0, and `apre_en` and `sec_tick` read 0.
- R2: While counting, `apre_en` is a one-cycle pulse. It occurs every A + 1 counting clock cycles. The first pulse follows the A + 1 th counting edge.
- R3: `subsec` decreases by one on each `apre_en` pulse. On the pulse after it reaches 0, it reloads to S, and `sec_tick` pulses in that same cycle. The tick period is (A + 1) × (S + 1) cycles.
- R4: `init_ready` goes high after the second consecutive rising edge at which `init_req` is sampled high. It goes low after the first edge at which `init_req` is sampled low.
- R5: A write (`cfg_we` high) at an edge where `init_ready` is low leaves both dividers unchanged.
- R6: While `init_req` is high, `subsec` shows S, and no `apre_en` or `sec_tick` pulse is produced.
- R7: After `init_req` is first sampled low at edge E0, the counters stay held through edge E3. Counting starts at edge E4.
- R8: A write at an edge where `init_ready` is high loads `cfg_async` into A and `cfg_sync` into S. This includes the edge at which `init_req` is first sampled low. `subsec` shows the new S from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RTC reference clock |
| rst | input | 1 | Synchronous active-high reset |
| init_req | input | 1 | Request to stop counting and allow divider writes |
| cfg_we | input | 1 | Write strobe for both divider values |
| cfg_async | input | 7 | New asynchronous divider value A |
| cfg_sync | input | 15 | New synchronous divider value S |
| sec_tick | output | 1 | One-cycle pulse once per divided period |
| apre_en | output | 1 | One-cycle intermediate enable from the asynchronous stage |
| subsec | output | 15 | Current synchronous counter value |
| init_ready | output | 1 | High while divider writes are accepted |

## Verification
The hardest case to reach from the ports is a write landing on the edge where the init request has just dropped. At that edge the registered ready flag is still high, so the write must be taken. The held counters must pick up the new values before the restart delay ends. The stimulus drops `init_req` and raises `cfg_we` on the same falling edge. It loads A = 0 and S = 0, the degenerate setting where both pulses fire on every counting cycle. A one-cycle init pulse, which never raises ready, is also applied to exercise the restart delay on its own.

// File: rtl/rtc_div_pkg.sv
package rtc_div_pkg;
  localparam int ASYNC_W     = 7;
  localparam int SYNC_W      = 15;
  localparam int RESTART_CYC = 4;
  localparam logic [ASYNC_W-1:0] ASYNC_RST = 7'd127;
  localparam logic [SYNC_W-1:0]  SYNC_RST  = 15'd255;
endpackage

// File: rtl/rtc_init_ctrl.sv
module rtc_init_ctrl #(
  parameter int RESTART = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic init_req,
  output logic init_ready,
  output logic hold
);
  localparam int GW = $clog2(RESTART + 1);

  logic          req_q;
  logic [GW-1:0] gap;

  assign hold = init_req || (gap != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q      <= 1'b0;
      init_ready <= 1'b0;
      gap        <= '0;
    end else begin
      req_q      <= init_req;
      init_ready <= init_req && req_q;
      if (init_req)        gap <= GW'(RESTART);
      else if (gap != '0)  gap <= gap - 1'b1;
    end
  end

  // R4: ready only after two sampled requests
  p_ready_two_r4: assert property (@(posedge clk) disable iff (rst)
    init_ready |-> ($past(init_req) && $past(init_req, 2)));
  // R7: restart delay is active after a dropped request
  p_restart_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(init_req) |-> hold);
endmodule

// File: rtl/rtc_async_stage.sv
module rtc_async_stage #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic [W-1:0] reload,
  input  logic [W-1:0] rst_val,
  output logic         wrap,
  output logic         pulse
);
  logic [W-1:0] cnt;

  assign wrap = !hold && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= rst_val;
      pulse <= 1'b0;
    end else if (hold) begin
      cnt   <= reload;
      pulse <= 1'b0;
    end else begin
      cnt   <= wrap ? reload : cnt - 1'b1;
      pulse <= wrap;
    end
  end

  // R2: counter never leaves its reload range
  p_async_range_r2: assert property (@(posedge clk) disable iff (rst)
    (!hold && $past(!hold)) |-> (cnt <= reload));
endmodule

// File: rtl/rtc_sync_stage.sv
module rtc_sync_stage #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic         step,
  input  logic [W-1:0] reload,
  input  logic [W-1:0] rst_val,
  output logic [W-1:0] cnt,
  output logic         tick
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= rst_val;
      tick <= 1'b0;
    end else if (hold) begin
      cnt  <= reload;
      tick <= 1'b0;
    end else if (step) begin
      cnt  <= (cnt == '0) ? reload : cnt - 1'b1;
      tick <= (cnt == '0);
    end else begin
      tick <= 1'b0;
    end
  end

  // R3: a tick always lands on a reloaded count
  p_tick_reload_r3: assert property (@(posedge clk) disable iff (rst)
    tick |-> (cnt == reload));
endmodule

// File: rtl/rtc_tick_divider.sv
module rtc_tick_divider
  import rtc_div_pkg::*;
#(
  parameter int AW = ASYNC_W,
  parameter int SW = SYNC_W,
  parameter int RESTART = RESTART_CYC,
  parameter logic [AW-1:0] A_RST = ASYNC_RST,
  parameter logic [SW-1:0] S_RST = SYNC_RST
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_req,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_async,
  input  logic [SW-1:0] cfg_sync,
  output logic          sec_tick,
  output logic          apre_en,
  output logic [SW-1:0] subsec,
  output logic          init_ready
);
  logic          hold, wrap, wr_ok;
  logic [AW-1:0] div_a, nxt_a;
  logic [SW-1:0] div_s, nxt_s;

  assign wr_ok = cfg_we && init_ready;
  assign nxt_a = wr_ok ? cfg_async : div_a;
  assign nxt_s = wr_ok ? cfg_sync  : div_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_a <= A_RST;
      div_s <= S_RST;
    end else begin
      div_a <= nxt_a;
      div_s <= nxt_s;
    end
  end

  rtc_init_ctrl #(.RESTART(RESTART)) u_init (
    .clk(clk), .rst(rst), .init_req(init_req),
    .init_ready(init_ready), .hold(hold)
  );

  rtc_async_stage #(.W(AW)) u_async (
    .clk(clk), .rst(rst), .hold(hold), .reload(nxt_a), .rst_val(A_RST),
    .wrap(wrap), .pulse(apre_en)
  );

  rtc_sync_stage #(.W(SW)) u_sync (
    .clk(clk), .rst(rst), .hold(hold), .step(wrap), .reload(nxt_s),
    .rst_val(S_RST), .cnt(subsec), .tick(sec_tick)
  );

  // R3: tick only coincides with the intermediate enable
  p_tick_with_apre_r3: assert property (@(posedge clk) disable iff (rst)
    sec_tick |-> apre_en);
  // R3: subsecond steps down by one per non-wrapping pulse
  p_sub_step_r3: assert property (@(posedge clk) disable iff (rst)
    (apre_en && !sec_tick) |-> (subsec == SW'($past(subsec) - 1'b1)));
  // R6: subsecond never above the stored divider
  p_sub_bound_r6: assert property (@(posedge clk) disable iff (rst)
    subsec <= div_s);
  // R6: no pulses out of a held cycle
  p_hold_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    hold |=> (!apre_en && !sec_tick));
  // R5: dividers keep their value without an accepted write
  p_ignore_r5: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we && init_ready) |=> (div_s == $past(div_s) && div_a == $past(div_a)));
endmodule

// File: tb/tb_rtc_tick_divider.sv
module tb_rtc_tick_divider;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init_req = 1'b0;
  logic cfg_we = 1'b0;
  logic [6:0]  cfg_async = '0;
  logic [14:0] cfg_sync = '0;
  logic sec_tick, apre_en, init_ready;
  logic [14:0] subsec;

  always #10 clk = ~clk;

  rtc_tick_divider dut (
    .clk(clk), .rst(rst), .init_req(init_req), .cfg_we(cfg_we),
    .cfg_async(cfg_async), .cfg_sync(cfg_sync), .sec_tick(sec_tick),
    .apre_en(apre_en), .subsec(subsec), .init_ready(init_ready)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string phase = "R1";

  // behavioural reference: dividers, counting-edge count, ready, gap
  int m_a, m_s, m_k, m_gap;
  bit m_r1, m_rdy, m_hold;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_a = 127; m_s = 255; m_k = 0; m_gap = 0; m_r1 = 0; m_rdy = 0;
    end else begin
      if (cfg_we && m_rdy) begin m_a = cfg_async; m_s = cfg_sync; end
      m_hold = init_req || (m_gap != 0);
      m_rdy = init_req && m_r1;
      m_r1 = init_req;
      if (init_req) m_gap = 4; else if (m_gap > 0) m_gap--;
      if (m_hold) m_k = 0; else m_k++;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s phase %s cyc %0d: actual %0d expected %0d", tag, phase, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      int e_sub, e_ap, e_tk;
      e_sub = m_s - ((m_k / (m_a + 1)) % (m_s + 1));
      e_ap  = (m_k > 0 && (m_k % (m_a + 1)) == 0) ? 1 : 0;
      e_tk  = (m_k > 0 && (m_k % ((m_a + 1) * (m_s + 1))) == 0) ? 1 : 0;
      chk("R3 subsec", subsec, e_sub);
      chk("R2 apre_en", apre_en, e_ap);
      chk("R3 sec_tick", sec_tick, e_tk);
      chk("R4 init_ready", init_ready, m_rdy);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #4000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog phase %s: actual hung expected done", phase);
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1: reset state right after release
    chk("R1 subsec", subsec, 255);
    chk("R1 init_ready", init_ready, 0);
    phase = "R3";
    idle(66000);
    // R5: write while running is ignored
    phase = "R5";
    cfg_we = 1; cfg_async = 3; cfg_sync = 4;
    idle(1);
    cfg_we = 0;
    idle(20);
    // R6/R8: init, accepted write, held counters
    phase = "R6";
    init_req = 1;
    idle(1);
    cfg_we = 1; cfg_async = 5; cfg_sync = 6; // not ready yet: ignored (R5)
    idle(1);
    cfg_we = 0;
    idle(2);
    phase = "R8";
    cfg_we = 1; cfg_async = 3; cfg_sync = 4;
    idle(1);
    cfg_we = 0;
    chk("R8 subsec", subsec, 4);
    idle(5);
    // R7: release and restart
    phase = "R7";
    init_req = 0;
    idle(200);
    // R8: write on the edge the request drops, degenerate dividers
    phase = "R8";
    init_req = 1;
    idle(4);
    init_req = 0; cfg_we = 1; cfg_async = 0; cfg_sync = 0;
    idle(1);
    cfg_we = 0;
    chk("R8 subsec", subsec, 0);
    idle(40);
    // R7: single-cycle request never raises ready
    phase = "R7";
    init_req = 1;
    idle(1);
    init_req = 0;
    idle(40);
    finish_run();
  end
endmodule